// File: doc/BRIEF.md
# Two-Stage Digital I/Q Upconverter

This block moves a complex baseband transmit stream up in frequency before it reaches a DAC, in two steps. The first step is fine tuning. A 26-bit phase accumulator steps once per input sample and addresses a quarter-wave sine table. A complex mixer then rotates each sample by the current phase. This step runs at one quarter of the DAC rate. The mixed stream is raised to the DAC rate by holding each sample for four DAC clocks. The second step is a coarse shift by a quarter or an eighth of the DAC rate. It uses only swaps and sign changes, plus one constant scaling for the eighth-rate diagonals. The coarse shift sits directly in front of the DAC output register.

Upstream logic presents one sample with `inValid` high for a single DAC clock, every fourth clock. Software-style writes set the tuning word and a control word. The control word carries the fine enable, the coarse mode, the shift direction and a self-clearing phase-clear bit.

Top module: `iq_upconverter`

## Requirements
- R1: Synchronous reset clears the outputs, the phase accumulator and the rotation index. It disables fine tuning and selects coarse bypass.
- R2: A sample presented with `inValid` high at rising edge E is captured at E. Its fine-stage result reaches the output after edge E+2 and is held through edge E+5. With fine tuning disabled the mixer passes the sample through unchanged.
- R3: The phase accumulator is 26 bits wide. Each captured sample uses the current accumulator value and then adds the tuning word, wrapping modulo 2^26. The phase index is accumulator bits [25:16].
- R4: The table value at index p is round(32767·sin(2π(p+0.5)/1024)); cosine is the entry at p+256. The mixer computes I·cos − Q·sin and I·sin + Q·cos, adds 2^14, shifts right arithmetically by 15 and saturates to [−8192, 8191].
- R5: A write to address 0 (data bits [25:0]) loads the tuning word. The first increment that uses it follows the next captured sample.
- R6: A write to address 1 with data bit 4 set clears the accumulator at that edge. The next captured sample uses phase 0. The bit is not stored.
- R7: Address 1 bits [2:1] select the coarse mode: 0 or 3 is bypass, 1 is quarter-rate, 2 is eighth-rate. In bypass the output equals the held mixer value.
- R8: The rotation index k counts DAC edges since reset. In quarter-rate mode the output is (I,Q), (−Q,I), (−I,−Q), (Q,−I) for k mod 4 = 0, 1, 2, 3. Negation saturates (−8192 becomes 8191).
- R9: In eighth-rate mode the output is the held sample rotated by πk/4. The diagonal terms use the constant 23170/32768, and the result is rounded (add 2^14, shift 15) and saturated.
- R10: Address 1 bit 3 reverses the coarse rotation to −πk/4, which conjugates the sine term. Address 1 bit 0 enables fine tuning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DAC-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 1 | 0: tuning word, 1: control word |
| cfgData | input | 26 | Configuration write data |
| inValid | input | 1 | Input sample strobe, one clock in four |
| inI | input | 14 | Input in-phase sample, signed |
| inQ | input | 14 | Input quadrature sample, signed |
| outI | output | 14 | DAC-rate in-phase output, signed |
| outQ | output | 14 | DAC-rate quadrature output, signed |

## Verification
A captured sample reaches the output after the second rising edge following its capture edge and stays there for four edges. The coarse rotation applied at each output edge is the number of edges since reset released. A tuning word written between samples first changes the phase of the sample after the next one, while a phase clear makes the very next sample use phase zero. The bench tracks the edge index itself, activates each expected held value exactly two edges after its capture, and compares `outI` and `outQ` at every falling edge in between.

// File: rtl/upconv_pkg.sv
package upconv_pkg;

  localparam int PHASE_W = 26;
  localparam int ROT_W   = 3;

  typedef enum logic [1:0] {
    CM_BYPASS  = 2'd0,
    CM_QUARTER = 2'd1,
    CM_EIGHTH  = 2'd2
  } coarse_mode_e;

  typedef struct packed {
    logic               capture;
    logic               mixLoad;
    logic               clearPhase;
    logic               fineEn;
    logic               negShift;
    coarse_mode_e       coarseMode;
    logic [ROT_W-1:0]   rotIdx;
    logic [PHASE_W-1:0] tuneWord;
  } ctrl_t;

  localparam longint PI_Q30 = 64'sd3373259426;

  // Sine of (k+0.5)*pi/(2*depth) scaled by amp, by Taylor series in Q30.
  function automatic int quarterSine(input int k, input int depth, input int amp);
    longint x, x2, term, sum;
    x    = (longint'(2 * k + 1) * PI_Q30) / longint'(4 * depth);
    x2   = (x * x) >>> 30;
    term = x;
    sum  = x;
    for (int n = 1; n <= 9; n++) begin
      term = -((term * x2) >>> 30) / longint'((2 * n) * (2 * n + 1));
      sum  = sum + term;
    end
    return int'((sum * longint'(amp) + (longint'(1) <<< 29)) >>> 30);
  endfunction

  // round(2^(w-1) / sqrt(2)) by integer search.
  function automatic longint invRoot2(input int w);
    longint n, lo, hi, mid;
    n  = longint'(1) <<< (2 * w - 3);
    lo = 0;
    hi = longint'(1) <<< w;
    while (hi - lo > 1) begin
      mid = (lo + hi) / 2;
      if (mid * mid <= n) lo = mid;
      else hi = mid;
    end
    if (lo * lo + lo < n) lo = lo + 1;
    return lo;
  endfunction

endpackage

// File: rtl/upconv_sine_rom.sv
module upconv_sine_rom import upconv_pkg::*; #(
  parameter int IDX_W  = 10,
  parameter int SINE_W = 16
) (
  input  logic        [IDX_W-1:0]  phaseIdx,
  output logic signed [SINE_W-1:0] sinVal,
  output logic signed [SINE_W-1:0] cosVal
);
  localparam int Q_W    = IDX_W - 2;
  localparam int QDEPTH = 2 ** Q_W;
  localparam int AMP    = 2 ** (SINE_W - 1) - 1;

  logic signed [SINE_W-1:0] qTab [QDEPTH];

  for (genvar k = 0; k < QDEPTH; k++) begin : g_tab
    localparam int TV = quarterSine(k, QDEPTH, AMP);
    assign qTab[k] = SINE_W'(TV);
  end

  function automatic logic signed [SINE_W-1:0] look(input logic [IDX_W-1:0] p);
    logic [Q_W-1:0] addr;
    addr = p[Q_W] ? ~p[Q_W-1:0] : p[Q_W-1:0];
    return p[IDX_W-1] ? -qTab[addr] : qTab[addr];
  endfunction

  always_comb begin
    sinVal = look(phaseIdx);
    cosVal = look(phaseIdx + IDX_W'(QDEPTH));
  end
endmodule

// File: rtl/upconv_ctrl.sv
module upconv_ctrl import upconv_pkg::*; (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfgWe,
  input  logic               cfgAddr,
  input  logic [PHASE_W-1:0] cfgData,
  input  logic               inValid,
  output ctrl_t              ctrl
);
  logic               mixLoadQ;
  logic               fineEnQ;
  logic               negQ;
  coarse_mode_e       modeQ;
  logic [ROT_W-1:0]   rotQ;
  logic [PHASE_W-1:0] tuneQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      mixLoadQ <= 1'b0;
      fineEnQ  <= 1'b0;
      negQ     <= 1'b0;
      modeQ    <= CM_BYPASS;
      rotQ     <= '0;
      tuneQ    <= '0;
    end else begin
      mixLoadQ <= inValid;
      rotQ     <= rotQ + 1'b1;
      if (cfgWe && !cfgAddr) tuneQ <= cfgData;
      if (cfgWe && cfgAddr) begin
        fineEnQ <= cfgData[0];
        negQ    <= cfgData[3];
        case (cfgData[2:1])
          2'd1:    modeQ <= CM_QUARTER;
          2'd2:    modeQ <= CM_EIGHTH;
          default: modeQ <= CM_BYPASS;
        endcase
      end
    end
  end

  always_comb begin
    ctrl.capture    = inValid;
    ctrl.mixLoad    = mixLoadQ;
    ctrl.clearPhase = cfgWe && cfgAddr && cfgData[4];
    ctrl.fineEn     = fineEnQ;
    ctrl.negShift   = negQ;
    ctrl.coarseMode = modeQ;
    ctrl.rotIdx     = rotQ;
    ctrl.tuneWord   = tuneQ;
  end

  // R2
  mix_follows_capture_chk: assert property (@(posedge clk) disable iff (rst)
    inValid |=> ctrl.mixLoad);
endmodule

// File: rtl/upconv_datapath.sv
module upconv_datapath import upconv_pkg::*; #(
  parameter int DATA_W = 14,
  parameter int SINE_W = 16,
  parameter int IDX_W  = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  ctrl_t                    ctrl,
  input  logic signed [DATA_W-1:0] inI,
  input  logic signed [DATA_W-1:0] inQ,
  output logic signed [DATA_W-1:0] outI,
  output logic signed [DATA_W-1:0] outQ
);
  localparam int     SHIFT     = SINE_W - 1;
  localparam longint RND       = longint'(1) <<< (SINE_W - 2);
  localparam longint MAXV      = (longint'(1) <<< (DATA_W - 1)) - 1;
  localparam longint MINV      = -(longint'(1) <<< (DATA_W - 1));
  localparam longint HALF_ROOT = invRoot2(SINE_W);

  function automatic logic signed [DATA_W-1:0] satW(input longint v);
    if (v > MAXV) return DATA_W'(MAXV);
    if (v < MINV) return DATA_W'(MINV);
    return DATA_W'(v);
  endfunction

  function automatic longint scaleDiag(input longint v);
    return (v * HALF_ROOT + RND) >>> SHIFT;
  endfunction

  logic        [PHASE_W-1:0] phaseAcc;
  logic signed [DATA_W-1:0]  xI, xQ, mixI, mixQ;
  logic signed [SINE_W-1:0]  romSin, romCos, sinR, cosR;
  longint                    mixSumI, mixSumQ;
  longint                    wI, wQ, dSum, dDiff, rotI, rotQ;
  logic [2:0]                ang;

  upconv_sine_rom #(.IDX_W(IDX_W), .SINE_W(SINE_W)) i_rom (
    .phaseIdx (phaseAcc[PHASE_W-1 -: IDX_W]),
    .sinVal   (romSin),
    .cosVal   (romCos)
  );

  // Quarter-rate stage: capture sample and phase, then mix.
  always_ff @(posedge clk) begin
    if (rst) begin
      phaseAcc <= '0;
      xI <= '0; xQ <= '0;
      sinR <= '0; cosR <= '0;
      mixI <= '0; mixQ <= '0;
    end else begin
      if (ctrl.clearPhase)   phaseAcc <= '0;
      else if (ctrl.capture) phaseAcc <= phaseAcc + ctrl.tuneWord;
      if (ctrl.capture) begin
        xI <= inI; xQ <= inQ;
        sinR <= romSin; cosR <= romCos;
      end
      if (ctrl.mixLoad) begin
        mixI <= ctrl.fineEn ? satW((mixSumI + RND) >>> SHIFT) : xI;
        mixQ <= ctrl.fineEn ? satW((mixSumQ + RND) >>> SHIFT) : xQ;
      end
    end
  end

  always_comb begin
    mixSumI = longint'(xI) * longint'(cosR) - longint'(xQ) * longint'(sinR);
    mixSumQ = longint'(xI) * longint'(sinR) + longint'(xQ) * longint'(cosR);
  end

  // DAC-rate coarse rotation by ang * pi/4.
  always_comb begin
    case (ctrl.coarseMode)
      CM_QUARTER: ang = {ctrl.rotIdx[1:0], 1'b0};
      CM_EIGHTH:  ang = ctrl.rotIdx;
      default:    ang = 3'd0;
    endcase
    if (ctrl.negShift) ang = 3'd0 - ang;
    wI    = longint'(mixI);
    wQ    = longint'(mixQ);
    dSum  = wI + wQ;
    dDiff = wI - wQ;
    case (ang)
      3'd0:    begin rotI = wI;               rotQ = wQ;               end
      3'd1:    begin rotI = scaleDiag(dDiff); rotQ = scaleDiag(dSum);  end
      3'd2:    begin rotI = -wQ;              rotQ = wI;               end
      3'd3:    begin rotI = scaleDiag(-dSum); rotQ = scaleDiag(dDiff); end
      3'd4:    begin rotI = -wI;              rotQ = -wQ;              end
      3'd5:    begin rotI = scaleDiag(-dDiff); rotQ = scaleDiag(-dSum); end
      3'd6:    begin rotI = wQ;               rotQ = -wI;              end
      default: begin rotI = scaleDiag(dSum);  rotQ = scaleDiag(-dDiff); end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outI <= '0;
      outQ <= '0;
    end else begin
      outI <= satW(rotI);
      outQ <= satW(rotQ);
    end
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (outI == '0 && outQ == '0));

  // R3
  acc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.capture && !ctrl.clearPhase) |=> phaseAcc == $past(phaseAcc) + $past(ctrl.tuneWord));

  // R6
  clear_phase_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.clearPhase |=> phaseAcc == '0);

  // R7
  bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.coarseMode == CM_BYPASS |=> (outI == $past(mixI) && outQ == $past(mixQ)));

  // R8
  quarter_swap_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.coarseMode == CM_QUARTER && !ctrl.negShift && ctrl.rotIdx[1:0] == 2'd1 &&
     mixQ != DATA_W'(MINV)) |=> (outI == -$past(mixQ) && outQ == $past(mixI)));

  // R10
  quarter_neg_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.coarseMode == CM_QUARTER && ctrl.negShift && ctrl.rotIdx[1:0] == 2'd1 &&
     mixI != DATA_W'(MINV)) |=> (outI == $past(mixQ) && outQ == -$past(mixI)));
endmodule

// File: rtl/iq_upconverter.sv
module iq_upconverter import upconv_pkg::*; #(
  parameter int DATA_W = 14,
  parameter int SINE_W = 16,
  parameter int IDX_W  = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfgWe,
  input  logic                     cfgAddr,
  input  logic [PHASE_W-1:0]       cfgData,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inI,
  input  logic signed [DATA_W-1:0] inQ,
  output logic signed [DATA_W-1:0] outI,
  output logic signed [DATA_W-1:0] outQ
);
  ctrl_t ctrlBus;

  upconv_ctrl i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .cfgWe   (cfgWe),
    .cfgAddr (cfgAddr),
    .cfgData (cfgData),
    .inValid (inValid),
    .ctrl    (ctrlBus)
  );

  upconv_datapath #(.DATA_W(DATA_W), .SINE_W(SINE_W), .IDX_W(IDX_W)) i_datapath (
    .clk  (clk),
    .rst  (rst),
    .ctrl (ctrlBus),
    .inI  (inI),
    .inQ  (inQ),
    .outI (outI),
    .outQ (outQ)
  );
endmodule

// File: tb/test_iq_upconverter.sv
module test_iq_upconverter;
  localparam int CLK_PERIOD = 10;
  localparam real TWO_PI = 6.283185307179586;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfgWe = 1'b0;
  logic cfgAddr = 1'b0;
  logic [25:0] cfgData = '0;
  logic inValid = 1'b0;
  logic signed [13:0] inI = '0;
  logic signed [13:0] inQ = '0;
  logic signed [13:0] outI, outQ;

  int checks = 0;
  int failures = 0;
  int edgeIdx = -1;
  bit finished = 1'b0;

  int curI, curQ, pendI, pendQ, pendFrom, cMode, cNeg, cTol;
  string curTag, pendTag;
  bit haveCur;

  iq_upconverter i_iq_upconverter (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .inValid(inValid), .inI(inI), .inQ(inQ), .outI(outI), .outQ(outQ)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int sat14(input longint v);
    if (v > 8191) return 8191;
    if (v < -8192) return -8192;
    return int'(v);
  endfunction

  function automatic longint tabVal(input int p);
    return longint'(int'(32767.0 * $sin(TWO_PI * (real'(p % 1024) + 0.5) / 1024.0)));
  endfunction

  task automatic checkVal(input string tag, input int act, input int exp, input int tol);
    checks++;
    if (act - exp > tol || exp - act > tol) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Coarse rotation by a*pi/4 with Q15 cos/sin (R8, R9, R10).
  task automatic expCoarse(input int e, input int mi, input int mq, output int oi, output int oq);
    int a;
    longint c, s;
    if (cMode == 0) a = 0;
    else if (cMode == 1) a = 2 * (e % 4);
    else a = e % 8;
    if (cNeg != 0) a = (8 - a) % 8;
    case (a)
      0: begin c = 32768;  s = 0;      end
      1: begin c = 23170;  s = 23170;  end
      2: begin c = 0;      s = 32768;  end
      3: begin c = -23170; s = 23170;  end
      4: begin c = -32768; s = 0;      end
      5: begin c = -23170; s = -23170; end
      6: begin c = 0;      s = -32768; end
      default: begin c = 23170; s = -23170; end
    endcase
    oi = sat14((longint'(mi) * c - longint'(mq) * s + 16384) >>> 15);
    oq = sat14((longint'(mi) * s + longint'(mq) * c + 16384) >>> 15);
  endtask

  task automatic step();
    @(posedge clk);
    edgeIdx++;
    @(negedge clk);
  endtask

  task automatic stepObs();
    int oi, oq;
    step();
    if (edgeIdx == pendFrom) begin
      curI = pendI; curQ = pendQ; curTag = pendTag; haveCur = 1'b1;
    end
    if (haveCur) begin
      expCoarse(edgeIdx, curI, curQ, oi, oq);
      checkVal({curTag, " outI"}, int'(outI), oi, cTol);
      checkVal({curTag, " outQ"}, int'(outQ), oq, cTol);
    end
  endtask

  task automatic writeCfg(input bit addr, input logic [25:0] data);
    cfgWe = 1'b1; cfgAddr = addr; cfgData = data;
    stepObs();
    cfgWe = 1'b0;
  endtask

  task automatic runCase(input int fineOn, input int mode, input int neg, input int pat);
    longint bAcc, bTw, tw2;
    logic [25:0] ctrlWord;
    int xi, xq, idx;
    longint c, s;
    string coarseTag;
    cMode = mode; cNeg = neg; cTol = (fineOn != 0) ? 2 : 0;
    haveCur = 1'b0; pendFrom = -100;
    coarseTag = (neg != 0 && mode != 0) ? "R10" : (mode == 0) ? "R7" : (mode == 1) ? "R8" : "R9";
    bAcc = 0;
    bTw  = (pat == 0) ? 64'h0123457 : (longint'(127) <<< 16);
    tw2  = (pat == 0) ? 64'h3F00000 : 64'h2000000;
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
    edgeIdx = -1;
    // R1: outputs cleared by reset
    checkVal("R1 outI after reset", int'(outI), 0, 0);
    checkVal("R1 outQ after reset", int'(outQ), 0, 0);
    ctrlWord = 26'(fineOn) | 26'(mode << 1) | 26'(neg << 3);
    writeCfg(1'b0, 26'(bTw));
    writeCfg(1'b1, ctrlWord);
    checkVal("R1 outI idle after config", int'(outI), 0, 0);
    for (int smp = 0; smp < 16; smp++) begin
      if (pat == 0) begin
        xi = -8000 + smp * 1063;
        xq = 7000 - smp * 977;
      end else begin
        xi = (smp % 2 != 0) ? -8192 : 8191;
        xq = (smp % 3 == 0) ? -8192 : 8191;
      end
      inValid = 1'b1; inI = 14'(xi); inQ = 14'(xq);
      stepObs();
      inValid = 1'b0;
      idx = int'((bAcc >>> 16) & 1023);
      bAcc = (bAcc + bTw) & ((longint'(1) <<< 26) - 1);
      if (fineOn != 0) begin
        c = tabVal(idx + 256);
        s = tabVal(idx);
        pendI = sat14((longint'(xi) * c - longint'(xq) * s + 16384) >>> 15);
        pendQ = sat14((longint'(xi) * s + longint'(xq) * c + 16384) >>> 15);
        pendTag = (smp >= 12) ? {"R4 R6 ", coarseTag} : (smp >= 8) ? {"R4 R5 ", coarseTag}
                                                                 : {"R4 R3 ", coarseTag};
      end else begin
        pendI = xi; pendQ = xq;
        pendTag = {"R2 ", coarseTag};
      end
      pendFrom = edgeIdx + 2;
      if (smp == 7) begin
        writeCfg(1'b0, 26'(tw2));
        bTw = tw2;
      end else if (smp == 11) begin
        writeCfg(1'b1, ctrlWord | 26'h10);
        bAcc = 0;
      end else begin
        stepObs();
      end
      stepObs();
      stepObs();
    end
    for (int d = 0; d < 6; d++) stepObs();
  endtask

  initial begin
    for (int fineOn = 0; fineOn < 2; fineOn++)
      for (int mode = 0; mode < 3; mode++)
        for (int neg = 0; neg < 2; neg++)
          for (int pat = 0; pat < 2; pat++)
            runCase(fineOn, mode, neg, pat);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule